// File: doc/BRIEF.md
# ADC Code to Decimal Microvolt Converter

This block turns a raw 12-bit unipolar converter sample into a voltage in microvolts and presents it as packed BCD digits that a multiplexed seven-segment driver can read directly. Full scale (a code of 4096) stands for 1 V. The scaling needs no divider. The code is multiplied by 15625 to give a 30-bit product, and the six low bits are then dropped, which is the same as multiplying by 1,000,000 and dividing by 4096. The multiply comes first, so no low-order precision is lost before scaling.

The 24-bit binary microvolt value is then converted to decimal by a shift-and-add-3 sequencer. The sequencer takes one clock per binary bit. This replaces a chain of divide-by-ten and modulo stages and keeps each cycle's logic shallow at a fast system clock. It works because a display never needs a new value at the sample rate. When an input is biased up by half scale to carry negative swings, a signed mode subtracts the half-scale reading of 500000 µV. The block then reports a sign flag and the magnitude.

A sample is taken only when the block is idle. The digits and sign hold their last value until the next conversion finishes, and a one-cycle strobe marks each new result.

Top module: `adc_uv_bcd`

## Requirements
- R1: A synchronous active-high reset, even in the middle of a conversion, clears the digits and the sign flag to zero, clears the done strobe, and returns the block to idle. No result from the interrupted conversion ever appears.
- R2: In unsigned mode the digits equal the decimal form of floor(code × 15625 / 64). Examples: code 0 gives 0, code 1 gives 244, and code 4095 gives 999755.
- R3: A sample is accepted on a rising edge where the valid input is high and the block is idle. The done strobe is high in the cycle that follows the 25th rising edge, counting the accepting edge as the first.
- R4: A valid sample that arrives while a conversion is in progress is ignored. It produces no extra done strobe and does not change the pending result.
- R5: The digits and the sign flag change only on the edge that raises done. At all other times they hold their last value.
- R6: In signed mode, which is sampled on the accepting edge, the sign flag is 1 exactly when the scaled value is below 500000. The digits then hold |scaled − 500000|. Examples: code 0 gives −500000, code 2047 gives −245, code 2048 gives +0, and code 4095 gives +499755.
- R7: In unsigned mode the sign flag is 0 with every result.
- R8: Digit k (k = 0 is the least significant) sits in bits [4k+3:4k] of the digit output as an unsigned value from 0 to 9. Digits above the value's most significant digit are 0.
- R9: The done strobe is high for exactly one cycle per accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| code_valid_i | input | 1 | Sample strobe for code_i |
| code_i | input | 12 | Unsigned converter code |
| signed_mode_i | input | 1 | 1 = subtract the half-scale reading and report sign and magnitude |
| bcd_o | output | 32 | Eight packed BCD digits, least significant digit in the low nibble |
| neg_o | output | 1 | Sign of the last result (1 = negative) |
| done_o | output | 1 | One-cycle pulse when bcd_o and neg_o are updated |

## Verification
A wrong scaling constant or a wrong shift shows up as a wrong digit pattern at the very next done strobe. The bench catches it with codes at zero, one, full scale and near the half-scale boundary. A shift counter that runs long or short moves the done strobe away from its 25-cycle slot. It also leaves shifted-garbage digits that may exceed 9, and both are visible on the first conversion. A sequencer that does not stay busy lets a second sample restart the conversion. This shows within one conversion as a wrong result or an unexpected extra strobe. A result register that is not held shows as digits drifting between strobes.

// File: rtl/uv_pkg.sv
package uv_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;
endpackage

// File: rtl/uv_scaler.sv
module uv_scaler #(
    parameter int CODE_W = 12,
    parameter int SCALE_K = 15625,
    parameter int SCALE_SH = 6,
    parameter int UV_W = 24
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              signed_mode_i,
    output logic [UV_W-1:0]   mag_o,
    output logic              neg_o
);
    localparam int PROD_W = CODE_W + 18;
    localparam longint MID_L = ((longint'(1) << (CODE_W - 1)) * longint'(SCALE_K)) >>> SCALE_SH;
    localparam logic [UV_W-1:0] MID_UV = UV_W'(MID_L);

    logic [PROD_W-1:0] prod;
    logic [UV_W-1:0]   uv;

    always_comb begin
        // multiply first, then drop the low bits
        prod = PROD_W'(code_i) * PROD_W'(SCALE_K);
        uv   = UV_W'(prod >> SCALE_SH);
        if (!signed_mode_i) begin
            mag_o = uv;
            neg_o = 1'b0;
        end else if (uv < MID_UV) begin
            mag_o = MID_UV - uv;
            neg_o = 1'b1;
        end else begin
            mag_o = uv - MID_UV;
            neg_o = 1'b0;
        end
    end
endmodule

// File: rtl/dabble_conv.sv
module dabble_conv
    import uv_pkg::*;
#(
    parameter int BIN_W = 24,
    parameter int NDIG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BIN_W-1:0]  bin_i,
    input  logic              neg_i,
    output logic              busy_o,
    output logic [4*NDIG-1:0] bcd_o,
    output logic              neg_o,
    output logic              done_o
);
    localparam int BCD_W = 4 * NDIG;
    localparam int CNT_W = $clog2(BIN_W + 1);

    typedef struct packed {
        conv_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [BIN_W-1:0] shreg;
        logic [BCD_W-1:0] work;
        logic             sgn;
        logic [BCD_W-1:0] bcd;
        logic             neg;
        logic             done;
    } conv_t;

    conv_t q, d;
    logic [BCD_W-1:0] adj;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        adj    = q.work;
        for (int k = 0; k < NDIG; k++) begin
            if (q.work[4*k +: 4] >= 4'd5) adj[4*k +: 4] = q.work[4*k +: 4] + 4'd3;
        end
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_RUN;
                    d.cnt   = '0;
                    d.shreg = bin_i;
                    d.work  = '0;
                    d.sgn   = neg_i;
                end
            end
            default: begin
                d.work  = {adj[BCD_W-2:0], q.shreg[BIN_W-1]};
                d.shreg = {q.shreg[BIN_W-2:0], 1'b0};
                d.cnt   = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(BIN_W - 1)) begin
                    d.st   = ST_IDLE;
                    d.bcd  = {adj[BCD_W-2:0], q.shreg[BIN_W-1]};
                    d.neg  = q.sgn;
                    d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st == ST_RUN);
    assign bcd_o  = q.bcd;
    assign neg_o  = q.neg;
    assign done_o = q.done;

    logic digits_ok;
    always_comb begin
        digits_ok = 1'b1;
        for (int k = 0; k < NDIG; k++) begin
            if (q.bcd[4*k +: 4] > 4'd9) digits_ok = 1'b0;
        end
    end

    p_digit_range_r8: assert property (@(posedge clk) disable iff (rst)
        q.done |-> digits_ok);

    p_accept_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && start_i) |=> (q.st == ST_RUN && q.cnt == '0));

    p_ignore_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_RUN && start_i && q.cnt != CNT_W'(BIN_W - 1)) |=> (q.st == ST_RUN && q.cnt == $past(q.cnt) + 1'b1));
endmodule

// File: rtl/adc_uv_bcd.sv
module adc_uv_bcd #(
    parameter int CODE_W = 12,
    parameter int SCALE_K = 15625,
    parameter int SCALE_SH = 6,
    parameter int UV_W = 24,
    parameter int NDIG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_valid_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              signed_mode_i,
    output logic [4*NDIG-1:0] bcd_o,
    output logic              neg_o,
    output logic              done_o
);
    logic [UV_W-1:0] mag;
    logic            mag_neg;
    logic            busy;

    uv_scaler #(
        .CODE_W(CODE_W), .SCALE_K(SCALE_K), .SCALE_SH(SCALE_SH), .UV_W(UV_W)
    ) u_scale (
        .code_i(code_i),
        .signed_mode_i(signed_mode_i),
        .mag_o(mag),
        .neg_o(mag_neg)
    );

    dabble_conv #(
        .BIN_W(UV_W), .NDIG(NDIG)
    ) u_conv (
        .clk(clk),
        .rst(rst),
        .start_i(code_valid_i),
        .bin_i(mag),
        .neg_i(mag_neg),
        .busy_o(busy),
        .bcd_o(bcd_o),
        .neg_o(neg_o),
        .done_o(done_o)
    );

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(bcd_o) && $stable(neg_o)));

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> !busy);
endmodule

// File: tb/adc_uv_bcd_bench.sv
module adc_uv_bcd_bench;
    localparam int NDIG = 8;
    localparam int LAT = 25;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              code_valid_i = 1'b0;
    logic [11:0]       code_i = '0;
    logic              signed_mode_i = 1'b0;
    logic [4*NDIG-1:0] bcd_o;
    logic              neg_o;
    logic              done_o;

    adc_uv_bcd u_adc_uv_bcd (
        .clk(clk), .rst(rst), .code_valid_i(code_valid_i), .code_i(code_i),
        .signed_mode_i(signed_mode_i), .bcd_o(bcd_o), .neg_o(neg_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [4*NDIG-1:0] bcd;
        logic              neg;
        int                due;
        logic              sm;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    logic [4*NDIG-1:0] last_bcd = '0;
    logic last_neg = 1'b0;
    logic prev_done = 1'b0;

    always @(posedge clk) cyc++;

    function automatic logic [4*NDIG-1:0] to_bcd(input longint v);
        logic [4*NDIG-1:0] r;
        longint t;
        r = '0;
        t = v;
        for (int i = 0; i < NDIG; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic send(input int code, input logic sm, input logic push);
        exp_t e;
        longint uv;
        @(negedge clk);
        code_i = 12'(code);
        signed_mode_i = sm;
        code_valid_i = 1'b1;
        if (push) begin
            uv = (longint'(code) * 15625) / 64;
            e.sm = sm;
            e.neg = 1'b0;
            if (sm) begin
                if (uv < 500000) begin
                    e.neg = 1'b1;
                    uv = 500000 - uv;
                end else begin
                    uv = uv - 500000;
                end
            end
            e.bcd = to_bcd(uv);
            e.due = cyc + LAT;
            exp_q.push_back(e);
        end
        @(negedge clk);
        code_valid_i = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic convert(input int code, input logic sm);
        send(code, sm, 1'b1);
        drain();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o && prev_done) begin
                checks++; errors++;
                $display("FAIL R9: done high two cycles, actual 1 expected 0");
            end
            if (done_o && !prev_done) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4: unexpected done, actual 1 expected 0 at cycle %0d", cyc);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (bcd_o !== e.bcd) begin
                        errors++;
                        $display("FAIL %s: digits actual %h expected %h", e.sm ? "R6" : "R2", bcd_o, e.bcd);
                    end
                    checks++;
                    if (neg_o !== e.neg) begin
                        errors++;
                        $display("FAIL %s: sign actual %0b expected %0b", e.sm ? "R6" : "R7", neg_o, e.neg);
                    end
                    checks++;
                    if (cyc != e.due) begin
                        errors++;
                        $display("FAIL R3: done cycle actual %0d expected %0d", cyc, e.due);
                    end
                    last_bcd = e.bcd;
                    last_neg = e.neg;
                end
            end
        end
        prev_done = done_o;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (bcd_o !== '0 || neg_o !== 1'b0 || done_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs actual %h/%0b/%0b expected 0/0/0", bcd_o, neg_o, done_o);
        end
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2, R7, R8: unsigned results
        convert(0, 1'b0);
        convert(1, 1'b0);
        convert(4095, 1'b0);
        convert(2048, 1'b0);
        convert(1000, 1'b0);
        convert(37, 1'b0);

        // R6: signed results around half scale
        convert(0, 1'b1);
        convert(2047, 1'b1);
        convert(2048, 1'b1);
        convert(4095, 1'b1);
        convert(2049, 1'b1);

        // R4: sample during conversion is ignored
        send(100, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        send(3000, 1'b1, 1'b0);
        drain();
        repeat (30) @(negedge clk);
        checks++;
        if (bcd_o !== to_bcd(24414) || neg_o !== 1'b0) begin
            errors++;
            $display("FAIL R4: result actual %h/%0b expected %h/0", bcd_o, neg_o, to_bcd(24414));
        end

        // R5: outputs hold between strobes
        repeat (20) @(negedge clk);
        checks++;
        if (bcd_o !== last_bcd || neg_o !== last_neg) begin
            errors++;
            $display("FAIL R5: held value actual %h/%0b expected %h/%0b", bcd_o, neg_o, last_bcd, last_neg);
        end

        // back-to-back: valid straight after done is accepted
        send(4000, 1'b0, 1'b1);
        while (!done_o) @(negedge clk);
        send(7, 1'b0, 1'b1);
        drain();

        // R1: reset in mid-conversion
        send(4095, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (bcd_o !== '0 || neg_o !== 1'b0 || done_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: mid-run reset actual %h/%0b/%0b expected 0/0/0", bcd_o, neg_o, done_o);
        end
        rst = 1'b0;
        repeat (40) @(negedge clk);
        checks++;
        if (bcd_o !== '0) begin
            errors++;
            $display("FAIL R1: aborted result appeared, actual %h expected 0", bcd_o);
        end

        convert(2222, 1'b0);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3: missing done, actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule